// File: doc/BRIEF.md
# Status-Decoded Bus Command Generator

This block sits beside a processor that announces each bus cycle on three active-low status lines. It follows the clock phases of every cycle and turns the announced cycle type into system command strobes: memory read, memory write, early memory write, I/O read, I/O write, early I/O write and interrupt acknowledge. It also drives an address-latch enable pulse, a data-buffer enable and a data-direction line for the transceivers. All outputs are registered and change only on the processor clock edge.

A cycle begins when the status lines leave the passive code 111 while the block is idle. The code seen on that edge is latched for the rest of the cycle. After the latch pulse, the read-type commands and the early write commands assert. The normal write commands assert one clock later. The block then stays in its data phase while the ready input is low. After ready has been seen, the block releases everything on the first edge at which the status is passive again.

Top module: `bus_cmd_gen`

## Requirements
- R1: While `rst` is high at a clock edge, the next outputs are: every command strobe high (inactive), `ale` low, `den` low, `dt_rn` high.
- R2: When the block is idle and `stat_n` is not 111 at an edge, `ale` is high for exactly the following clock (phase T1). `ale` is low at all other times, including while `stat_n` stays 111.
- R3: The latched code selects the command as follows. 000 gives `irq_ack_n`. 001 gives `io_rd_n`. 010 gives `io_wr_n` and `io_awr_n`. 100 and 101 give `mem_rd_n`. 110 gives `mem_wr_n` and `mem_awr_n`. No other strobe is active in that cycle.
- R4: Code 011 (halt) runs the T1 phase with an `ale` pulse, but asserts no strobe and no `den`.
- R5: Read-type strobes and early write strobes go low one clock after `ale` (phase T2).
- R6: `mem_wr_n` and `io_wr_n` go low one clock after their early counterparts (phase T3), and are never low while the early strobe is high.
- R7: For codes 000, 001, 100 and 101, `dt_rn` is low from T1 until the cycle ends. It is high at all other times.
- R8: `den` is high from T2 until the cycle ends for every code except 011, and it is high whenever any strobe is low.
- R9: In T3 with `rdy` low, the phase does not advance. The strobes stay asserted across these wait clocks, even if `stat_n` has already returned to 111.
- R10: After an edge with `rdy` high in T3 (phase T4), all strobes, `den` and `dt_rn` return to their inactive levels on the first edge where `stat_n` is 111. Until then they hold.
- R11: Changes on `stat_n` after T1 other than the final return to 111 do not change the strobes of the running cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Processor clock |
| rst | input | 1 | Synchronous active-high reset |
| stat_n | input | 3 | Active-low cycle status code, 111 = passive |
| rdy | input | 1 | Ready; low inserts wait clocks in T3 |
| ale | output | 1 | Address-latch enable pulse in T1 |
| den | output | 1 | Data-buffer enable |
| dt_rn | output | 1 | Data direction, low = toward processor |
| irq_ack_n | output | 1 | Interrupt acknowledge strobe |
| io_rd_n | output | 1 | I/O read strobe |
| io_wr_n | output | 1 | I/O write strobe |
| io_awr_n | output | 1 | Early I/O write strobe |
| mem_rd_n | output | 1 | Memory read strobe |
| mem_wr_n | output | 1 | Memory write strobe |
| mem_awr_n | output | 1 | Early memory write strobe |

## Verification
Every one of the eight status codes is driven as a zero-wait cycle. These runs separate the two memory-read codes from the I/O and acknowledge decodes, and show that halt and passive stay quiet apart from the latch pulse. A write cycle with ready held low, during which the status returns to passive, shows whether the release waits for the T4 phase or follows the status alone. A read cycle whose status switches to a write code after T1 shows whether the code is latched or followed live. Between cycles the status rests at passive, which tests that no pulse starts without a new code.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

  localparam int STAT_W = 3;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_T1,
    PH_T2,
    PH_T3,
    PH_T4
  } phase_e;

  typedef enum logic [2:0] {
    K_INTA,
    K_IORD,
    K_IOWR,
    K_HALT,
    K_MEMRD,
    K_MEMWR,
    K_NONE
  } kind_e;

  function automatic kind_e code_to_kind(input logic [STAT_W-1:0] c);
    kind_e k;
    case (c)
      3'b000:          k = K_INTA;
      3'b001:          k = K_IORD;
      3'b010:          k = K_IOWR;
      3'b011:          k = K_HALT;
      3'b100, 3'b101:  k = K_MEMRD;
      3'b110:          k = K_MEMWR;
      default:         k = K_NONE;
    endcase
    return k;
  endfunction

endpackage

// File: rtl/bcg_decode.sv
module bcg_decode
  import bcg_pkg::*;
(
  input  logic [STAT_W-1:0] stat_n,
  output kind_e             kind
);
  always_comb kind = code_to_kind(stat_n);
endmodule

// File: rtl/bcg_seq.sv
module bcg_seq
  import bcg_pkg::*;
#(
  parameter logic [STAT_W-1:0] PASSIVE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_n,
  input  logic              rdy,
  input  kind_e             live_kind,
  output phase_e            ph_d,
  output kind_e             kind_d
);
  phase_e ph_q;
  kind_e  kind_q;
  logic   passive;

  assign passive = (stat_n == PASSIVE);

  always_comb begin
    ph_d   = ph_q;
    kind_d = kind_q;
    case (ph_q)
      PH_IDLE: if (!passive) begin
        ph_d   = PH_T1;
        kind_d = live_kind;
      end
      PH_T1:   ph_d = PH_T2;
      PH_T2:   ph_d = PH_T3;
      PH_T3:   if (rdy) ph_d = PH_T4;
      PH_T4:   if (passive) begin
        ph_d   = PH_IDLE;
        kind_d = K_NONE;
      end
      default: ph_d = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q   <= PH_IDLE;
      kind_q <= K_NONE;
    end else begin
      ph_q   <= ph_d;
      kind_q <= kind_d;
    end
  end

  // R9: a low ready keeps the data phase in place
  a_r9_wait_hold: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T3 && !rdy) |=> (ph_q == PH_T3));

  // R10: the cycle ends only on a passive status
  a_r10_end_on_passive: assert property (@(posedge clk) disable iff (rst)
    (ph_q == PH_T4 && !passive) |=> (ph_q == PH_T4));

  // R11: the latched kind survives status changes inside the cycle
  a_r11_kind_latched: assert property (@(posedge clk) disable iff (rst)
    (ph_q != PH_IDLE && ph_q != PH_T4) |=> $stable(kind_q));

endmodule

// File: rtl/bcg_strobe.sv
module bcg_strobe
  import bcg_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  phase_e ph_d,
  input  kind_e  kind_d,
  output logic   ale,
  output logic   den,
  output logic   dt_rn,
  output logic   irq_ack_n,
  output logic   io_rd_n,
  output logic   io_wr_n,
  output logic   io_awr_n,
  output logic   mem_rd_n,
  output logic   mem_wr_n,
  output logic   mem_awr_n
);
  logic early, late, rd_kind;

  assign early   = (ph_d == PH_T2) || (ph_d == PH_T3) || (ph_d == PH_T4);
  assign late    = (ph_d == PH_T3) || (ph_d == PH_T4);
  assign rd_kind = (kind_d == K_INTA) || (kind_d == K_IORD) || (kind_d == K_MEMRD);

  always_ff @(posedge clk) begin
    if (rst) begin
      ale       <= 1'b0;
      den       <= 1'b0;
      dt_rn     <= 1'b1;
      irq_ack_n <= 1'b1;
      io_rd_n   <= 1'b1;
      io_wr_n   <= 1'b1;
      io_awr_n  <= 1'b1;
      mem_rd_n  <= 1'b1;
      mem_wr_n  <= 1'b1;
      mem_awr_n <= 1'b1;
    end else begin
      ale       <= (ph_d == PH_T1);
      den       <= early && (kind_d != K_HALT) && (kind_d != K_NONE);
      dt_rn     <= !((ph_d != PH_IDLE) && rd_kind);
      irq_ack_n <= !(early && kind_d == K_INTA);
      io_rd_n   <= !(early && kind_d == K_IORD);
      io_awr_n  <= !(early && kind_d == K_IOWR);
      io_wr_n   <= !(late  && kind_d == K_IOWR);
      mem_rd_n  <= !(early && kind_d == K_MEMRD);
      mem_awr_n <= !(early && kind_d == K_MEMWR);
      mem_wr_n  <= !(late  && kind_d == K_MEMWR);
    end
  end

  // R2: the latch pulse lasts one clock
  a_r2_ale_single: assert property (@(posedge clk) disable iff (rst)
    ale |=> !ale);

  // R3: at most one command family is active
  a_r3_one_family: assert property (@(posedge clk) disable iff (rst)
    $onehot0({!irq_ack_n, !io_rd_n, !io_awr_n, !mem_rd_n, !mem_awr_n}));

  // R6: normal writes never lead the early writes
  a_r6_mem_wr_order: assert property (@(posedge clk) disable iff (rst)
    $fell(mem_wr_n) |-> $past(!mem_awr_n));
  a_r6_io_wr_order: assert property (@(posedge clk) disable iff (rst)
    $fell(io_wr_n) |-> $past(!io_awr_n));

  // R8: data buffers are enabled under every strobe
  a_r8_den_cover: assert property (@(posedge clk) disable iff (rst)
    (!irq_ack_n || !io_rd_n || !io_wr_n || !io_awr_n ||
     !mem_rd_n || !mem_wr_n || !mem_awr_n) |-> den);

endmodule

// File: rtl/bus_cmd_gen.sv
module bus_cmd_gen
  import bcg_pkg::*;
#(
  parameter logic [STAT_W-1:0] PASSIVE = '1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [STAT_W-1:0] stat_n,
  input  logic              rdy,
  output logic              ale,
  output logic              den,
  output logic              dt_rn,
  output logic              irq_ack_n,
  output logic              io_rd_n,
  output logic              io_wr_n,
  output logic              io_awr_n,
  output logic              mem_rd_n,
  output logic              mem_wr_n,
  output logic              mem_awr_n
);
  kind_e  live_kind, kind_d;
  phase_e ph_d;

  bcg_decode u_dec (
    .stat_n (stat_n),
    .kind   (live_kind)
  );

  bcg_seq #(.PASSIVE(PASSIVE)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .stat_n    (stat_n),
    .rdy       (rdy),
    .live_kind (live_kind),
    .ph_d      (ph_d),
    .kind_d    (kind_d)
  );

  bcg_strobe u_stb (
    .clk       (clk),
    .rst       (rst),
    .ph_d      (ph_d),
    .kind_d    (kind_d),
    .ale       (ale),
    .den       (den),
    .dt_rn     (dt_rn),
    .irq_ack_n (irq_ack_n),
    .io_rd_n   (io_rd_n),
    .io_wr_n   (io_wr_n),
    .io_awr_n  (io_awr_n),
    .mem_rd_n  (mem_rd_n),
    .mem_wr_n  (mem_wr_n),
    .mem_awr_n (mem_awr_n)
  );

  // R4: a halt cycle never opens the data buffers
  a_r4_halt_quiet: assert property (@(posedge clk) disable iff (rst)
    (ale && $past(stat_n) == 3'b011) |=> !den);

endmodule

// File: tb/tb_bus_cmd_gen.sv
module tb_bus_cmd_gen;
  localparam time CLK_PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [2:0] stat_n = 3'b111;
  logic       rdy = 1'b1;
  logic ale, den, dt_rn, irq_ack_n, io_rd_n, io_wr_n, io_awr_n;
  logic mem_rd_n, mem_wr_n, mem_awr_n;

  int n_tests = 0;
  int n_fail  = 0;
  int cyc     = 0;
  bit done    = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_cmd_gen dut (
    .clk(clk), .rst(rst), .stat_n(stat_n), .rdy(rdy),
    .ale(ale), .den(den), .dt_rn(dt_rn), .irq_ack_n(irq_ack_n),
    .io_rd_n(io_rd_n), .io_wr_n(io_wr_n), .io_awr_n(io_awr_n),
    .mem_rd_n(mem_rd_n), .mem_wr_n(mem_wr_n), .mem_awr_n(mem_awr_n)
  );

  // behavioural reference: phase 0 idle, 1..4 = T1..T4
  int m_ph   = 0;
  int m_code = 7;

  always @(posedge clk) begin
    cyc++;
    if (rst) begin
      m_ph = 0; m_code = 7;
    end else begin
      case (m_ph)
        0: if (stat_n != 3'b111) begin m_ph = 1; m_code = int'(stat_n); end
        1: m_ph = 2;
        2: m_ph = 3;
        3: if (rdy) m_ph = 4;
        default: if (stat_n == 3'b111) begin m_ph = 0; m_code = 7; end
      endcase
    end
  end

  // order: irq_ack, io_rd, io_wr, io_awr, mem_rd, mem_wr, mem_awr (active low)
  function automatic logic [6:0] exp_strb(int ph, int code);
    logic [6:0] v = 7'h7f;
    bit e = (ph >= 2);
    bit l = (ph >= 3);
    if (e && code == 0) v[6] = 1'b0;
    if (e && code == 1) v[5] = 1'b0;
    if (l && code == 2) v[4] = 1'b0;
    if (e && code == 2) v[3] = 1'b0;
    if (e && (code == 4 || code == 5)) v[2] = 1'b0;
    if (l && code == 6) v[1] = 1'b0;
    if (e && code == 6) v[0] = 1'b0;
    return v;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s at cycle %0d: got %h expected %h", tag, cyc, got, exp);
    end
  endtask

  logic [6:0] strb;
  assign strb = {irq_ack_n, io_rd_n, io_wr_n, io_awr_n, mem_rd_n, mem_wr_n, mem_awr_n};

  // per-clock comparison against the reference
  always @(negedge clk) begin
    if (!rst && !done) begin
      logic [6:0] es;
      bit e_den, e_dt;
      es    = exp_strb(m_ph, m_code);
      e_den = (m_ph >= 2) && m_code != 3 && m_code != 7;
      e_dt  = !((m_ph != 0) && (m_code == 0 || m_code == 1 || m_code == 4 || m_code == 5));
      check(ale == (m_ph == 1), "R2 ale", {7'd0, ale}, {7'd0, m_ph == 1});
      check(strb == es, "R3 strobes", {1'b0, strb}, {1'b0, es});
      check(den == e_den, "R8 den", {7'd0, den}, {7'd0, e_den});
      check(dt_rn == e_dt, "R7 dt_rn", {7'd0, dt_rn}, {7'd0, e_dt});
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) tick();
    // R1: reset levels
    check(strb == 7'h7f && !ale && !den && dt_rn, "R1 reset",
          {ale, strb}, {1'b0, 7'h7f});
    rst = 1'b0;
    repeat (3) tick();

    for (int c = 0; c < 8; c++) begin
      stat_n = 3'(c);
      tick();                                  // T1
      if (c != 7) check(ale == 1'b1, "R2 pulse", {7'd0, ale}, 8'd1);
      else        check(ale == 1'b0, "R2 passive", {7'd0, ale}, 8'd0);
      tick();                                  // T2
      if (c == 3) check(strb == 7'h7f && !den, "R4 halt", {den, strb}, {1'b0, 7'h7f});
      if (c == 1) check(io_rd_n == 1'b0, "R5 io read", {7'd0, io_rd_n}, 8'd0);
      if (c == 6) check(mem_awr_n == 1'b0 && mem_wr_n == 1'b1, "R6 early first",
                        {6'd0, mem_awr_n, mem_wr_n}, 8'd1);
      tick();                                  // T3
      if (c == 2) check(io_wr_n == 1'b0, "R6 late write", {7'd0, io_wr_n}, 8'd0);
      stat_n = 3'b111;
      tick();                                  // T4
      if (c == 4) check(mem_rd_n == 1'b0, "R10 hold in T4", {7'd0, mem_rd_n}, 8'd0);
      tick();                                  // released
      check(strb == 7'h7f && !den && dt_rn, "R10 release", {den, strb}, {1'b0, 7'h7f});
      tick();
    end

    // wait states with status already passive
    rdy = 1'b0;
    stat_n = 3'b110;
    tick(); tick(); tick();                    // T1, T2, T3
    stat_n = 3'b111;
    for (int w = 0; w < 3; w++) begin
      tick();
      check(mem_wr_n == 1'b0 && mem_awr_n == 1'b0, "R9 wait hold",
            {6'd0, mem_wr_n, mem_awr_n}, 8'd0);
    end
    rdy = 1'b1;
    tick();                                    // T4
    check(mem_wr_n == 1'b0, "R9 T4 after ready", {7'd0, mem_wr_n}, 8'd0);
    tick();
    check(mem_wr_n == 1'b1 && mem_awr_n == 1'b1, "R10 after wait",
          {6'd0, mem_wr_n, mem_awr_n}, 8'd3);
    tick();

    // status switches code mid-cycle
    stat_n = 3'b001;
    tick();                                    // T1
    stat_n = 3'b010;
    tick();                                    // T2
    check(io_rd_n == 1'b0 && io_awr_n == 1'b1, "R11 latched code",
          {6'd0, io_rd_n, io_awr_n}, 8'd1);
    tick();
    check(io_wr_n == 1'b1 && dt_rn == 1'b0, "R11 no write",
          {6'd0, io_wr_n, dt_rn}, 8'd2);
    stat_n = 3'b111;
    repeat (4) tick();

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule